// File: doc/BRIEF.md
# Processor Error Flag and Halt Controller

This block keeps a processor's two error status bits: an Error flag, raised by faults found in the datapath, and a halt-on-error enable bit. It decides when the processor stops. Error is driven straight onto an external pin so that other processors or a supervising unit can see it at once. When a fault raises Error while halt-on-error is already enabled, the block asks the processor to halt. It then waits for the serial link engines to finish their transfers, and only after that grants the link shutdown. Memory refresh stays enabled the whole time.

A two-level scheduler signals when a high priority context preempts a low priority one, and when that context ends. On preemption the block saves both flags. The high priority context starts with the same Error value and with halt-on-error cleared. When the context ends, the saved values are restored. An external analysis request also halts the processor and blocks outgoing links from fetching new data. For either kind of halt, the block captures an instruction pointer and pulses a load strobe for the A register. Once entered, the halt state holds until reset.

Top module: `err_halt_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, error_pin, hoe_flag, halt_req, link_shutdown, fetch_block, areg_load and cap_ip are all 0. Reset is synchronous and active-high.
- R2: Any set bit of err_src sets Error at the next clock edge. The bits are 0 overflow, 1 divide by zero, 2 bounds violation and 3 software set. error_pin shows the Error flag register with no other logic in the path.
- R3: sw_err_clr clears Error at the next edge unless an err_src bit is set in the same cycle, in which case the set wins. sw_hoe_set and sw_hoe_clr set and clear hoe_flag in the same way, and the set wins.
- R4: halt_req rises at the edge where an err_src bit takes Error from 0 to 1 while hoe_flag was already 1 in that cycle.
- R5: No error halt occurs when Error is already 1, or when hoe_flag is set in the same cycle as the error or later.
- R6: A preempt_start with no high priority context active saves both flags, keeps Error, and clears hoe_flag at the next edge. Error events and flag writes in that cycle are dropped, and so is any error halt they would cause.
- R7: A preempt_end with a high priority context active restores both saved flags at the next edge, whatever the high priority code did.
- R8: A preempt_start while a context is already active, and a preempt_end while none is active, are ignored. Flag writes and events in that cycle still apply.
- R9: After a halt, link_shutdown rises at the edge that ends the first cycle in which halt_req is 1 and every link_busy bit is 0. It then stays 1.
- R10: refresh_en becomes 1 at the first edge with reset low and stays 1, including while halted.
- R11: analyse_req while not halted causes a halt at the next edge, and fetch_block is 1 from that edge on. An error halt never sets fetch_block.
- R12: At the halt edge, areg_load pulses for exactly one cycle. cap_ip becomes instr_ptr+1+err_late (modulo 2^IP_W) for an error halt, or instr_ptr+1 for an analysis halt. If both happen in the same cycle, the error halt wins.
- R13: halt_req stays 1 until reset, and later requests neither recapture cap_ip nor pulse areg_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_src | input | SRC_W | Error events: overflow, divide by zero, bounds, software set |
| sw_err_clr | input | 1 | Software clear of Error |
| sw_hoe_set | input | 1 | Software set of halt-on-error |
| sw_hoe_clr | input | 1 | Software clear of halt-on-error |
| preempt_start | input | 1 | High priority context begins |
| preempt_end | input | 1 | High priority context ends |
| analyse_req | input | 1 | External analysis halt request |
| link_busy | input | NUM_LINKS | Per-link transfer in progress |
| instr_ptr | input | IP_W | Address of the current instruction |
| err_late | input | 1 | Fetch had advanced one extra byte when the error was detected |
| error_pin | output | 1 | External Error pin |
| hoe_flag | output | 1 | Current halt-on-error flag |
| halt_req | output | 1 | Processor halt request |
| link_shutdown | output | 1 | Link shutdown grant after drain |
| fetch_block | output | 1 | Outgoing links barred from new data fetches |
| refresh_en | output | 1 | Memory refresh enable |
| areg_load | output | 1 | One-cycle strobe to copy cap_ip into register A |
| cap_ip | output | IP_W | Captured instruction pointer |

## Verification
A wrong flag value shows on error_pin or hoe_flag one edge after the cycle that caused it. An error in the preemption save register shows up later, at the edge after preempt_end, when the restored flags are wrong. A badly formed halt trigger shows within one edge as a wrong halt_req, areg_load or cap_ip. A broken drain check shows as link_shutdown rising early while links are busy, or never rising. The bench compares every output against a behavioural model on every cycle, so each of these shows up in the first cycle it is visible.

// File: rtl/err_halt_pkg.sv
package err_halt_pkg;

    typedef struct packed {
        logic err;
        logic hoe;
    } flag_pair_t;

    typedef enum logic [1:0] {
        HS_RUN   = 2'd0,
        HS_DRAIN = 2'd1,
        HS_STOP  = 2'd2
    } halt_state_e;

    typedef enum logic [1:0] {
        HC_NONE    = 2'd0,
        HC_ERROR   = 2'd1,
        HC_ANALYSE = 2'd2
    } halt_cause_e;

    // set has priority over clear
    function automatic logic flag_next(logic cur, logic set, logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

    // flags seen by a freshly started high priority context
    function automatic flag_pair_t enter_high(flag_pair_t cur);
        flag_pair_t r;
        r.err = cur.err;
        r.hoe = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ehc_flag_bank.sv
module ehc_flag_bank
    import err_halt_pkg::*;
#(
    parameter int SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] err_src,
    input  logic             sw_err_clr,
    input  logic             sw_hoe_set,
    input  logic             sw_hoe_clr,
    input  logic             preempt_start,
    input  logic             preempt_end,
    output flag_pair_t       live_o,
    output logic             hi_act_o,
    output logic             err_trig_o
);
    flag_pair_t live_q, live_d, saved_q, saved_d;
    logic       act_q, act_d;
    logic       any_evt, enter, leave;

    always_comb begin
        any_evt = |err_src;
        enter   = preempt_start && !act_q;
        leave   = preempt_end && act_q;
        live_d  = live_q;
        saved_d = saved_q;
        act_d   = act_q;
        if (enter) begin
            saved_d = live_q;
            live_d  = enter_high(live_q);
            act_d   = 1'b1;
        end else if (leave) begin
            live_d  = saved_q;
            act_d   = 1'b0;
        end else begin
            live_d.err = flag_next(live_q.err, any_evt, sw_err_clr);
            live_d.hoe = flag_next(live_q.hoe, sw_hoe_set, sw_hoe_clr);
        end
        err_trig_o = !enter && !leave && !live_q.err && any_evt && live_q.hoe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= '0;
            saved_q <= '0;
            act_q   <= 1'b0;
        end else begin
            live_q  <= live_d;
            saved_q <= saved_d;
            act_q   <= act_d;
        end
    end

    assign live_o   = live_q;
    assign hi_act_o = act_q;

endmodule

// File: rtl/ehc_ip_capture.sv
module ehc_ip_capture #(
    parameter int IP_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take_err,
    input  logic            take_an,
    input  logic [IP_W-1:0] instr_ptr,
    input  logic            err_late,
    output logic [IP_W-1:0] cap_ip,
    output logic            areg_load
);
    localparam logic [IP_W-1:0] ONE = {{(IP_W-1){1'b0}}, 1'b1};

    logic [IP_W-1:0] extra;
    logic [IP_W-1:0] cap_q;
    logic            load_q;

    assign extra = take_err ? {{(IP_W-1){1'b0}}, err_late} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= take_err || take_an;
            if (take_err || take_an)
                cap_q <= instr_ptr + ONE + extra;
        end
    end

    assign cap_ip    = cap_q;
    assign areg_load = load_q;

endmodule

// File: rtl/ehc_halt_seq.sv
module ehc_halt_seq
    import err_halt_pkg::*;
#(
    parameter int NUM_LINKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 err_trig,
    input  logic                 analyse_req,
    input  logic [NUM_LINKS-1:0] link_busy,
    output logic                 take_err,
    output logic                 take_an,
    output logic                 halt_req,
    output logic                 link_shutdown,
    output logic                 fetch_block,
    output logic                 refresh_en
);
    halt_state_e state_q, state_d;
    halt_cause_e cause_q, cause_d;
    logic        ref_q;
    logic        links_idle;

    always_comb begin
        links_idle = ~|link_busy;
        take_err   = (state_q == HS_RUN) && err_trig;
        take_an    = (state_q == HS_RUN) && analyse_req && !err_trig;
        state_d    = state_q;
        cause_d    = cause_q;
        unique case (state_q)
            HS_RUN: begin
                if (take_err) begin
                    state_d = HS_DRAIN;
                    cause_d = HC_ERROR;
                end else if (take_an) begin
                    state_d = HS_DRAIN;
                    cause_d = HC_ANALYSE;
                end
            end
            HS_DRAIN: if (links_idle) state_d = HS_STOP;
            HS_STOP:  state_d = HS_STOP;
            default:  state_d = HS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_RUN;
            cause_q <= HC_NONE;
            ref_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            ref_q   <= 1'b1;
        end
    end

    assign halt_req      = (state_q != HS_RUN);
    assign link_shutdown = (state_q == HS_STOP);
    assign fetch_block   = (cause_q == HC_ANALYSE);
    assign refresh_en    = ref_q;

endmodule

// File: rtl/err_halt_ctrl.sv
module err_halt_ctrl
    import err_halt_pkg::*;
#(
    parameter int SRC_W     = 4,
    parameter int NUM_LINKS = 4,
    parameter int IP_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_W-1:0]     err_src,
    input  logic                 sw_err_clr,
    input  logic                 sw_hoe_set,
    input  logic                 sw_hoe_clr,
    input  logic                 preempt_start,
    input  logic                 preempt_end,
    input  logic                 analyse_req,
    input  logic [NUM_LINKS-1:0] link_busy,
    input  logic [IP_W-1:0]      instr_ptr,
    input  logic                 err_late,
    output logic                 error_pin,
    output logic                 hoe_flag,
    output logic                 halt_req,
    output logic                 link_shutdown,
    output logic                 fetch_block,
    output logic                 refresh_en,
    output logic                 areg_load,
    output logic [IP_W-1:0]      cap_ip
);
    flag_pair_t live;
    logic       hi_act;
    logic       err_trig;
    logic       take_err, take_an;

    ehc_flag_bank #(.SRC_W(SRC_W)) u_flags (
        .clk(clk), .rst(rst), .err_src(err_src),
        .sw_err_clr(sw_err_clr), .sw_hoe_set(sw_hoe_set), .sw_hoe_clr(sw_hoe_clr),
        .preempt_start(preempt_start), .preempt_end(preempt_end),
        .live_o(live), .hi_act_o(hi_act), .err_trig_o(err_trig)
    );

    ehc_halt_seq #(.NUM_LINKS(NUM_LINKS)) u_seq (
        .clk(clk), .rst(rst), .err_trig(err_trig), .analyse_req(analyse_req),
        .link_busy(link_busy), .take_err(take_err), .take_an(take_an),
        .halt_req(halt_req), .link_shutdown(link_shutdown),
        .fetch_block(fetch_block), .refresh_en(refresh_en)
    );

    ehc_ip_capture #(.IP_W(IP_W)) u_cap (
        .clk(clk), .rst(rst), .take_err(take_err), .take_an(take_an),
        .instr_ptr(instr_ptr), .err_late(err_late),
        .cap_ip(cap_ip), .areg_load(areg_load)
    );

    assign error_pin = live.err;
    assign hoe_flag  = live.hoe;

endmodule

// File: rtl/err_halt_ctrl_chk.sv
module err_halt_ctrl_chk #(
    parameter int SRC_W     = 4,
    parameter int NUM_LINKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [SRC_W-1:0]     err_src,
    input logic                 preempt_start,
    input logic                 preempt_end,
    input logic                 analyse_req,
    input logic [NUM_LINKS-1:0] link_busy,
    input logic                 error_pin,
    input logic                 hoe_flag,
    input logic                 halt_req,
    input logic                 link_shutdown,
    input logic                 fetch_block,
    input logic                 refresh_en,
    input logic                 areg_load,
    input logic                 hi_act
);
    // R2
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|err_src && !preempt_start && !preempt_end) |=> error_pin);
    // R4
    halt_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!halt_req && !error_pin && hoe_flag && |err_src && !preempt_start && !preempt_end)
        |=> (halt_req && areg_load));
    // R5
    no_halt_err_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!halt_req && error_pin && !analyse_req) |=> !halt_req);
    // R6
    preempt_save_chk: assert property (@(posedge clk) disable iff (rst)
        (preempt_start && !hi_act) |=> (!hoe_flag && error_pin == $past(error_pin) && hi_act));
    // R7
    preempt_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (preempt_end && hi_act) |=> !hi_act);
    // R8
    nested_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (preempt_start && hi_act && !preempt_end) |=> hi_act);
    // R9
    shutdown_after_halt_chk: assert property (@(posedge clk) disable iff (rst)
        link_shutdown |-> halt_req);
    // R9
    shutdown_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !link_shutdown && link_busy == '0) |=> link_shutdown);
    // R10
    refresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_en |=> refresh_en);
    // R11
    analyse_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!halt_req && analyse_req && error_pin) |=> (halt_req && fetch_block));
    // R12
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        areg_load |=> !areg_load);
    // R12
    load_with_halt_chk: assert property (@(posedge clk) disable iff (rst)
        areg_load |-> (halt_req && !$past(halt_req)));
    // R13
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> halt_req);
endmodule

bind err_halt_ctrl err_halt_ctrl_chk #(.SRC_W(SRC_W), .NUM_LINKS(NUM_LINKS)) u_chk (
    .clk(clk), .rst(rst), .err_src(err_src),
    .preempt_start(preempt_start), .preempt_end(preempt_end),
    .analyse_req(analyse_req), .link_busy(link_busy),
    .error_pin(error_pin), .hoe_flag(hoe_flag), .halt_req(halt_req),
    .link_shutdown(link_shutdown), .fetch_block(fetch_block),
    .refresh_en(refresh_en), .areg_load(areg_load), .hi_act(hi_act)
);

// File: tb/err_halt_ctrl_bench.sv
module err_halt_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  err_src;
    logic        sw_err_clr, sw_hoe_set, sw_hoe_clr;
    logic        preempt_start, preempt_end, analyse_req;
    logic [3:0]  link_busy;
    logic [31:0] instr_ptr;
    logic        err_late;
    logic        error_pin, hoe_flag, halt_req, link_shutdown;
    logic        fetch_block, refresh_en, areg_load;
    logic [31:0] cap_ip;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    bit          m_err, m_hoe, s_err, s_hoe, m_act;
    bit          m_halt, m_stop, m_blk, m_ref, m_load;
    logic [31:0] m_cap;

    always #5 clk = ~clk;

    err_halt_ctrl u_err_halt_ctrl (
        .clk(clk), .rst(rst), .err_src(err_src),
        .sw_err_clr(sw_err_clr), .sw_hoe_set(sw_hoe_set), .sw_hoe_clr(sw_hoe_clr),
        .preempt_start(preempt_start), .preempt_end(preempt_end),
        .analyse_req(analyse_req), .link_busy(link_busy),
        .instr_ptr(instr_ptr), .err_late(err_late),
        .error_pin(error_pin), .hoe_flag(hoe_flag), .halt_req(halt_req),
        .link_shutdown(link_shutdown), .fetch_block(fetch_block),
        .refresh_en(refresh_en), .areg_load(areg_load), .cap_ip(cap_ip)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_next();
        bit ev, go_hi, go_lo, e_halt, a_halt;
        bit o_err, o_hoe, o_halt, o_stop;
        o_err = m_err; o_hoe = m_hoe; o_halt = m_halt; o_stop = m_stop;
        if (rst) begin
            m_err = 0; m_hoe = 0; s_err = 0; s_hoe = 0; m_act = 0;
            m_halt = 0; m_stop = 0; m_blk = 0; m_ref = 0; m_load = 0; m_cap = 0;
            return;
        end
        ev    = (err_src != 0);
        go_hi = preempt_start && !m_act;
        go_lo = preempt_end && m_act;
        if (go_hi) begin
            s_err = o_err; s_hoe = o_hoe; m_hoe = 0; m_act = 1;
        end else if (go_lo) begin
            m_err = s_err; m_hoe = s_hoe; m_act = 0;
        end else begin
            if (ev) m_err = 1; else if (sw_err_clr) m_err = 0;
            if (sw_hoe_set) m_hoe = 1; else if (sw_hoe_clr) m_hoe = 0;
        end
        e_halt = !o_halt && !go_hi && !go_lo && ev && !o_err && o_hoe;
        a_halt = !o_halt && analyse_req && !e_halt;
        m_load = e_halt || a_halt;
        if (e_halt) m_cap = instr_ptr + 32'd1 + (err_late ? 32'd1 : 32'd0);
        if (a_halt) begin
            m_cap = instr_ptr + 32'd1;
            m_blk = 1;
        end
        if (o_halt && !o_stop && link_busy == 0) m_stop = 1;
        if (m_load) m_halt = 1;
        m_ref = 1;
    endtask

    task automatic step();
        model_next();
        @(posedge clk);
        @(negedge clk);
        chk("R2 error_pin", {31'd0, error_pin}, {31'd0, m_err});
        chk("R3 hoe_flag", {31'd0, hoe_flag}, {31'd0, m_hoe});
        chk("R4 halt_req", {31'd0, halt_req}, {31'd0, m_halt});
        chk("R9 link_shutdown", {31'd0, link_shutdown}, {31'd0, m_stop});
        chk("R11 fetch_block", {31'd0, fetch_block}, {31'd0, m_blk});
        chk("R10 refresh_en", {31'd0, refresh_en}, {31'd0, m_ref});
        chk("R12 areg_load", {31'd0, areg_load}, {31'd0, m_load});
        chk("R12 cap_ip", cap_ip, m_cap);
    endtask

    task automatic idle_inputs();
        err_src = 0; sw_err_clr = 0; sw_hoe_set = 0; sw_hoe_clr = 0;
        preempt_start = 0; preempt_end = 0; analyse_req = 0;
        link_busy = 0; instr_ptr = 32'h8000_0100; err_late = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1;
        step(); step();
        chk("R1 error_pin", {31'd0, error_pin}, 0);
        chk("R1 hoe_flag", {31'd0, hoe_flag}, 0);
        chk("R1 halt_req", {31'd0, halt_req}, 0);
        chk("R1 link_shutdown", {31'd0, link_shutdown}, 0);
        chk("R1 fetch_block", {31'd0, fetch_block}, 0);
        chk("R1 areg_load", {31'd0, areg_load}, 0);
        chk("R1 cap_ip", cap_ip, 0);
        rst = 0;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        chk("R10 refresh after reset", {31'd0, refresh_en}, 1);

        // every error source sets Error; clear removes it
        for (int i = 0; i < 4; i++) begin
            err_src = 4'(1 << i); step(); err_src = 0;
            chk("R2 source sets", {31'd0, error_pin}, 1);
            sw_err_clr = 1; step(); sw_err_clr = 0;
            chk("R3 clear", {31'd0, error_pin}, 0);
        end
        // set wins over clear
        err_src = 4'b0001; sw_err_clr = 1; step(); idle_inputs();
        chk("R3 set wins err", {31'd0, error_pin}, 1);
        sw_err_clr = 1; step(); idle_inputs();
        sw_hoe_set = 1; sw_hoe_clr = 1; step(); idle_inputs();
        chk("R3 set wins hoe", {31'd0, hoe_flag}, 1);
        sw_hoe_clr = 1; step(); idle_inputs();
        chk("R3 hoe clear", {31'd0, hoe_flag}, 0);

        // no halt when enable comes with or after Error
        err_src = 4'b0010; step(); idle_inputs();
        sw_hoe_set = 1; step(); idle_inputs();
        chk("R5 hoe after err", {31'd0, halt_req}, 0);
        err_src = 4'b1000; step(); idle_inputs();
        chk("R5 err already set", {31'd0, halt_req}, 0);
        sw_err_clr = 1; sw_hoe_clr = 1; step(); idle_inputs();
        err_src = 4'b0001; sw_hoe_set = 1; step(); idle_inputs();
        chk("R5 same cycle", {31'd0, halt_req}, 0);

        // preemption with Error=1, hoe=0: Error passes in, restored at end
        sw_hoe_clr = 1; step(); idle_inputs();
        preempt_start = 1; err_src = 4'b0100; step(); idle_inputs();
        chk("R6 err kept", {31'd0, error_pin}, 1);
        sw_err_clr = 1; sw_hoe_set = 1; step(); idle_inputs();
        preempt_end = 1; step(); idle_inputs();
        chk("R7 err restored", {31'd0, error_pin}, 1);
        chk("R7 hoe restored", {31'd0, hoe_flag}, 0);

        // preemption with Error=0, hoe=1
        sw_err_clr = 1; sw_hoe_set = 1; step(); idle_inputs();
        preempt_start = 1; step(); idle_inputs();
        chk("R6 hoe cleared", {31'd0, hoe_flag}, 0);
        err_src = 4'b0010; step(); idle_inputs();
        chk("R6 no halt inside", {31'd0, halt_req}, 0);
        preempt_start = 1; sw_hoe_set = 1; step(); idle_inputs();
        chk("R8 nested start ignored", {31'd0, hoe_flag}, 1);
        preempt_end = 1; step(); idle_inputs();
        chk("R7 err restored 0", {31'd0, error_pin}, 0);
        chk("R7 hoe restored 1", {31'd0, hoe_flag}, 1);
        preempt_end = 1; sw_hoe_clr = 1; step(); idle_inputs();
        chk("R8 stray end ignored", {31'd0, hoe_flag}, 0);
        sw_hoe_set = 1; step(); idle_inputs();

        // error halt with busy links
        instr_ptr = 32'h8000_1230; err_late = 1; link_busy = 4'b0101;
        err_src = 4'b0100; step();
        err_src = 0;
        chk("R4 halt on rise", {31'd0, halt_req}, 1);
        chk("R12 error capture", cap_ip, 32'h8000_1232);
        step(); step(); step();
        chk("R9 waits for links", {31'd0, link_shutdown}, 0);
        link_busy = 4'b0001; step();
        link_busy = 0; step();
        chk("R9 shutdown after drain", {31'd0, link_shutdown}, 1);
        analyse_req = 1; instr_ptr = 32'h1234_0000; step(); step();
        chk("R13 no recapture", cap_ip, 32'h8000_1232);
        chk("R13 no load", {31'd0, areg_load}, 0);
        chk("R11 error halt no block", {31'd0, fetch_block}, 0);
        chk("R10 refresh while halted", {31'd0, refresh_en}, 1);

        // analysis halt
        do_reset();
        chk("R1 halt cleared", {31'd0, halt_req}, 0);
        instr_ptr = 32'h0000_0FFF; analyse_req = 1; step(); idle_inputs();
        chk("R11 analyse halt", {31'd0, fetch_block}, 1);
        chk("R12 analyse capture", cap_ip, 32'h0000_1000);
        step();
        chk("R9 idle links shutdown", {31'd0, link_shutdown}, 1);
        chk("R12 load one cycle", {31'd0, areg_load}, 0);

        // error and analysis in the same cycle, pointer wraps
        do_reset();
        sw_hoe_set = 1; step(); idle_inputs();
        err_src = 4'b0001; analyse_req = 1; instr_ptr = 32'hFFFF_FFFF; err_late = 1;
        step(); idle_inputs();
        chk("R12 error wins wrap", cap_ip, 32'h0000_0001);
        chk("R12 error wins no block", {31'd0, fetch_block}, 0);
        step(); step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule